// File: doc/BRIEF.md
# Receive Message FIFO Controller

This block buffers complete, already-validated messages for a message receiver such as a CAN controller. Each message has an identifier, a length code and an eight-byte payload, and arrives on a single-cycle write strobe. Up to three messages are held. The oldest message is always shown on an output mailbox port. It leaves the FIFO only when software pulses a release strobe.

A five-state control machine tracks the fill level and the overrun condition. The states are empty, one pending, two pending, three pending and overrun. The fill level is reported as a two-bit pending code. When a message arrives and no slot can take it, the message is dropped and a sticky overrun flag is set. Only a dedicated clear strobe or reset removes that flag. Storage is a circular buffer with separate read and write pointers.

Top module: `rx_msg_fifo`

## Requirements
- R1: After reset, pendCount is 00, ovrFlag is 0 and mbValid is 0.
- R2: A valid message arriving while the FIFO is empty is stored. One cycle later pendCount is 01 and the message's identifier, length and payload are on the mailbox outputs.
- R3: Each valid message that arrives without a release while one or two are pending raises pendCount by one. The mailbox keeps showing the oldest message.
- R4: A release while at least one message is pending lowers pendCount by one. The next oldest message, in arrival order, moves to the mailbox.
- R5: A release and a valid message in the same cycle while one is pending leave pendCount at 01, and the new message appears on the mailbox.
- R6: A valid message that arrives without a release while three are pending is discarded. ovrFlag becomes 1, pendCount stays 11, and the three stored messages are unchanged.
- R7: Further valid messages in the overrun state leave pendCount at 11 and ovrFlag at 1, and are discarded.
- R8: A release in the overrun state lowers pendCount to 10 and frees one slot, which the next valid message fills. ovrFlag stays 1.
- R9: ovrFlag clears only on an ovrClr strobe or on reset. If a message is lost in the same cycle as an ovrClr strobe, the flag is set rather than cleared.
- R10: A release while the FIFO is empty is ignored: pendCount stays 00 and mbValid stays 0.
- R11: mbValid is 1 exactly when pendCount is not 00.
- R12: A release and a valid message in the same cycle while two or three are pending leave pendCount unchanged. The oldest message is removed and the new one is stored, so no overrun occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| msgValid | input | 1 | One-cycle strobe: a complete valid message is present |
| msgId | input | ID_W | Identifier of the incoming message |
| msgLen | input | 4 | Length code of the incoming message |
| msgData | input | 64 | Payload of the incoming message |
| relStrobe | input | 1 | Software release of the mailbox (pop) |
| ovrClr | input | 1 | Clears the sticky overrun flag |
| pendCount | output | 2 | Number of pending messages (00 to 11) |
| ovrFlag | output | 1 | Sticky flag: a message was lost |
| mbValid | output | 1 | Mailbox holds a message |
| mbId | output | ID_W | Identifier of the oldest message |
| mbLen | output | 4 | Length code of the oldest message |
| mbData | output | 64 | Payload of the oldest message |

## Verification
Every result is due at the first rising edge after the strobes are sampled. pendCount and ovrFlag are registers, and the mailbox is a combinational read of a slot selected by the registered read pointer, so no result is ever due later than that edge. The bench drives strobes on the falling edge, waits for the next rising edge and samples one nanosecond after it. All outputs of a step are therefore checked together in the cycle they become due. Discarded messages are detected through the mailbox: after enough releases, the message that follows the survivors must be the first one accepted after the slot was freed.

// File: rtl/rx_msg_fifo_pkg.sv
package rx_msg_fifo_pkg;
  localparam int SLOTS    = 3;
  localparam int PTR_W    = 2;
  localparam int LEN_W    = 4;
  localparam int PAYLOAD_BYTES = 8;
  localparam int DATA_W   = PAYLOAD_BYTES * 8;

  // pending code lives in the low two bits of the state
  typedef enum logic [2:0] {
    ST_EMPTY = 3'b000,
    ST_ONE   = 3'b001,
    ST_TWO   = 3'b010,
    ST_THREE = 3'b011,
    ST_OVR   = 3'b111
  } fifoState_t;

  typedef struct packed {
    logic push;
    logic pop;
  } fifoCmd_t;
endpackage

// File: rtl/rx_msg_fifo_ctrl.sv
module rx_msg_fifo_ctrl
  import rx_msg_fifo_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     msgValid,
  input  logic     relStrobe,
  input  logic     ovrClr,
  output fifoCmd_t cmd,
  output logic [1:0] pendCount,
  output logic     ovrFlag,
  output logic     mbValid
);
  fifoState_t state, stateNext;
  logic       ovrReg, ovrNext;
  logic       isFull, doPop, doPush, lose;

  always_comb begin
    isFull = (state == ST_THREE) || (state == ST_OVR);
    doPop  = relStrobe && (state != ST_EMPTY);
    doPush = msgValid && (!isFull || doPop);
    lose   = msgValid && isFull && !doPop;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_EMPTY: if (doPush) stateNext = ST_ONE;
      ST_ONE: begin
        if (doPush && !doPop)      stateNext = ST_TWO;
        else if (doPop && !doPush) stateNext = ST_EMPTY;
      end
      ST_TWO: begin
        if (doPush && !doPop)      stateNext = ST_THREE;
        else if (doPop && !doPush) stateNext = ST_ONE;
      end
      ST_THREE: begin
        if (lose)                  stateNext = ST_OVR;
        else if (doPop && !doPush) stateNext = ST_TWO;
      end
      ST_OVR: begin
        if (doPop && !doPush)      stateNext = ST_TWO;
        else if (doPop && doPush)  stateNext = ST_OVR;
        else if (lose)             stateNext = ST_OVR;
        else if (ovrClr)           stateNext = ST_THREE;
      end
      default: stateNext = ST_EMPTY;
    endcase
  end

  always_comb begin
    ovrNext = ovrReg;
    if (lose)        ovrNext = 1'b1;
    else if (ovrClr) ovrNext = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_EMPTY;
      ovrReg <= 1'b0;
    end else begin
      state  <= stateNext;
      ovrReg <= ovrNext;
    end
  end

  assign cmd.push  = doPush;
  assign cmd.pop   = doPop;
  assign pendCount = state[1:0];
  assign ovrFlag   = ovrReg;
  assign mbValid   = (state != ST_EMPTY);
endmodule

// File: rtl/rx_msg_fifo_store.sv
module rx_msg_fifo_store
  import rx_msg_fifo_pkg::*;
#(
  parameter int ID_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoCmd_t          cmd,
  input  logic [ID_W-1:0]   inId,
  input  logic [LEN_W-1:0]  inLen,
  input  logic [DATA_W-1:0] inData,
  output logic [ID_W-1:0]   outId,
  output logic [LEN_W-1:0]  outLen,
  output logic [DATA_W-1:0] outData
);
  localparam int ENTRY_W = ID_W + LEN_W + DATA_W;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(SLOTS - 1);

  logic [ENTRY_W-1:0] slotMem [SLOTS];
  logic [PTR_W-1:0]   wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (cmd.push) wrPtr <= bump(wrPtr);
      if (cmd.pop)  rdPtr <= bump(rdPtr);
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        slotMem[s] <= '0;
      else if (cmd.push && (wrPtr == PTR_W'(s)))
        slotMem[s] <= {inId, inLen, inData};
    end
  end

  logic [ENTRY_W-1:0] head;
  always_comb begin
    head = '0;
    for (int s = 0; s < SLOTS; s++)
      if (rdPtr == PTR_W'(s)) head = slotMem[s];
  end

  assign {outId, outLen, outData} = head;
endmodule

// File: rtl/rx_msg_fifo.sv
module rx_msg_fifo
  import rx_msg_fifo_pkg::*;
#(
  parameter int ID_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              msgValid,
  input  logic [ID_W-1:0]   msgId,
  input  logic [3:0]        msgLen,
  input  logic [63:0]       msgData,
  input  logic              relStrobe,
  input  logic              ovrClr,
  output logic [1:0]        pendCount,
  output logic              ovrFlag,
  output logic              mbValid,
  output logic [ID_W-1:0]   mbId,
  output logic [3:0]        mbLen,
  output logic [63:0]       mbData
);
  fifoCmd_t cmd;

  rx_msg_fifo_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .msgValid  (msgValid),
    .relStrobe (relStrobe),
    .ovrClr    (ovrClr),
    .cmd       (cmd),
    .pendCount (pendCount),
    .ovrFlag   (ovrFlag),
    .mbValid   (mbValid)
  );

  rx_msg_fifo_store #(.ID_W(ID_W)) u_store (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .inId    (msgId),
    .inLen   (msgLen),
    .inData  (msgData),
    .outId   (mbId),
    .outLen  (mbLen),
    .outData (mbData)
  );
endmodule

// File: rtl/rx_msg_fifo_chk.sv
module rx_msg_fifo_chk #(
  parameter int ID_W = 11
) (
  input logic            clk,
  input logic            rstN,
  input logic            msgValid,
  input logic [ID_W-1:0] msgId,
  input logic            relStrobe,
  input logic            ovrClr,
  input logic [1:0]      pendCount,
  input logic            ovrFlag,
  input logic            mbValid,
  input logic [ID_W-1:0] mbId
);
  // R2
  first_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendCount == 2'd0 && msgValid) |=> (pendCount == 2'd1 && mbId == $past(msgId)));

  // R3
  fill_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !relStrobe && (pendCount == 2'd1 || pendCount == 2'd2))
      |=> (pendCount == $past(pendCount) + 2'd1 && $stable(mbId)));

  // R4
  drain_chk: assert property (@(posedge clk) disable iff (!rstN)
    (relStrobe && !msgValid && pendCount != 2'd0) |=> (pendCount == $past(pendCount) - 2'd1));

  // R6
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendCount == 2'd3 && msgValid && !relStrobe) |=> (ovrFlag && pendCount == 2'd3 && $stable(mbId)));

  // R9
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovrFlag && !ovrClr) |=> ovrFlag);

  // R10
  empty_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendCount == 2'd0 && relStrobe && !msgValid) |=> (pendCount == 2'd0 && !mbValid));

  // R11
  always_comb begin
    if (rstN) begin
      mailbox_valid_chk: assert (mbValid == (pendCount != 2'd0));
    end
  end
endmodule

bind rx_msg_fifo rx_msg_fifo_chk #(.ID_W(ID_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .msgValid  (msgValid),
  .msgId     (msgId),
  .relStrobe (relStrobe),
  .ovrClr    (ovrClr),
  .pendCount (pendCount),
  .ovrFlag   (ovrFlag),
  .mbValid   (mbValid),
  .mbId      (mbId)
);

// File: tb/rx_msg_fifo_bench.sv
module rx_msg_fifo_bench;
  localparam int ID_W = 11;
  localparam int NVEC = 19;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            msgValid = 1'b0;
  logic [ID_W-1:0] msgId = '0;
  logic [3:0]      msgLen = '0;
  logic [63:0]     msgData = '0;
  logic            relStrobe = 1'b0;
  logic            ovrClr = 1'b0;
  logic [1:0]      pendCount;
  logic            ovrFlag;
  logic            mbValid;
  logic [ID_W-1:0] mbId;
  logic [3:0]      mbLen;
  logic [63:0]     mbData;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rx_msg_fifo #(.ID_W(ID_W)) u_rx_msg_fifo (.*);

  // {valid, release, clear, tag[7:0], expPend[1:0], expOvr, expTag[7:0], req[3:0]}
  localparam logic [25:0] VEC [NVEC] = '{
    {3'b100, 8'hA1, 2'd1, 1'b0, 8'hA1, 4'd2},  // R2
    {3'b100, 8'hA2, 2'd2, 1'b0, 8'hA1, 4'd3},  // R3
    {3'b100, 8'hA3, 2'd3, 1'b0, 8'hA1, 4'd3},  // R3
    {3'b100, 8'hA4, 2'd3, 1'b1, 8'hA1, 4'd6},  // R6
    {3'b100, 8'hA5, 2'd3, 1'b1, 8'hA1, 4'd7},  // R7
    {3'b010, 8'h00, 2'd2, 1'b1, 8'hA2, 4'd8},  // R8
    {3'b100, 8'hA6, 2'd3, 1'b1, 8'hA2, 4'd8},  // R8
    {3'b001, 8'h00, 2'd3, 1'b0, 8'hA2, 4'd9},  // R9
    {3'b010, 8'h00, 2'd2, 1'b0, 8'hA3, 4'd4},  // R4
    {3'b010, 8'h00, 2'd1, 1'b0, 8'hA6, 4'd6},  // R6 discarded A4/A5
    {3'b110, 8'hA7, 2'd1, 1'b0, 8'hA7, 4'd5},  // R5
    {3'b010, 8'h00, 2'd0, 1'b0, 8'h00, 4'd4},  // R4
    {3'b010, 8'h00, 2'd0, 1'b0, 8'h00, 4'd10}, // R10
    {3'b100, 8'hA8, 2'd1, 1'b0, 8'hA8, 4'd2},  // R2
    {3'b100, 8'hA9, 2'd2, 1'b0, 8'hA8, 4'd3},  // R3
    {3'b110, 8'hAA, 2'd2, 1'b0, 8'hA9, 4'd12}, // R12
    {3'b100, 8'hAB, 2'd3, 1'b0, 8'hA9, 4'd3},  // R3
    {3'b110, 8'hAC, 2'd3, 1'b0, 8'hAA, 4'd12}, // R12
    {3'b101, 8'hAD, 2'd3, 1'b1, 8'hAA, 4'd9}   // R9 set wins over clear
  };

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkMailbox(input string req, input logic [1:0] ePend, input logic eOvr, input logic [7:0] eTag);
    check(req, "pendCount", 64'(pendCount), 64'(ePend));
    check(req, "ovrFlag", 64'(ovrFlag), 64'(eOvr));
    check("R11", "mbValid", 64'(mbValid), 64'(ePend != 2'd0));
    if (ePend != 2'd0) begin
      check(req, "mbId", 64'(mbId), 64'({3'b000, eTag}));
      check(req, "mbLen", 64'(mbLen), 64'(eTag[3:0]));
      check(req, "mbData", mbData, {8{eTag}});
    end
  endtask

  task automatic step(input logic v, input logic r, input logic c, input logic [7:0] tag);
    @(negedge clk);
    msgValid  = v;
    relStrobe = r;
    ovrClr    = c;
    msgId     = {3'b000, tag};
    msgLen    = tag[3:0];
    msgData   = {8{tag}};
    @(posedge clk);
    #1;
    msgValid  = 1'b0;
    relStrobe = 1'b0;
    ovrClr    = 1'b0;
  endtask

  initial begin
    #1;
    // R1 reset state
    check("R1", "pendCount", 64'(pendCount), 64'd0);
    check("R1", "ovrFlag", 64'(ovrFlag), 64'd0);
    check("R1", "mbValid", 64'(mbValid), 64'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      string req;
      req = $sformatf("R%0d", VEC[i][3:0]);
      step(VEC[i][25], VEC[i][24], VEC[i][23], VEC[i][22:15]);
      checkMailbox(req, VEC[i][14:13], VEC[i][12], VEC[i][11:4]);
    end

    // R8: after release in overrun, the freed slot takes the next message
    step(1'b0, 1'b1, 1'b0, 8'h00);
    checkMailbox("R8", 2'd2, 1'b1, 8'hAB);
    step(1'b1, 1'b0, 1'b0, 8'hAE);
    checkMailbox("R8", 2'd3, 1'b1, 8'hAB);

    // R1 reset mid-run
    @(negedge clk);
    rstN = 1'b0;
    #2;
    check("R1", "pendCount", 64'(pendCount), 64'd0);
    check("R1", "ovrFlag", 64'(ovrFlag), 64'd0);
    check("R1", "mbValid", 64'(mbValid), 64'd0);
    @(negedge clk);
    rstN = 1'b1;

    // R10 repeated release on empty, then a fresh write lands correctly
    step(1'b0, 1'b1, 1'b0, 8'h00);
    step(1'b0, 1'b1, 1'b0, 8'h00);
    checkMailbox("R10", 2'd0, 1'b0, 8'h00);
    step(1'b1, 1'b0, 1'b0, 8'h5C);
    checkMailbox("R2", 2'd1, 1'b0, 8'h5C);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule